// File: doc/BRIEF.md
# Gated Binary Counter

This block is a binary up-counter whose advance is governed by a one-bit run state. Two enable lines that are synchronous to the clock are compared with each other. When they agree (both low or both high), the counter runs. When they differ, it freezes. A run-force input, asynchronous to the clock, switches counting on at once and overrides the synchronous pair. An asynchronous clear forces the count to zero.

The run decision is taken on the same rising edge that would advance the count. An edge that stops counting therefore does not increment, and an edge that restarts counting does. The count is built as a fully synchronous toggle chain, not a ripple chain. The run state is brought out so that the host can see whether the counter is currently running. The block suits clock-division and interval-timing uses where counting must be started and stopped either from clocked logic or from an external strobe.

Top module: `gated_counter`

## Requirements
- R1: While clr_i is high, count_o is 0 and run_o is 1. Both take these values asynchronously, without waiting for a clock edge.
- R2: On a rising edge where the run decision is true, count_o becomes the previous count plus one.
- R3: On a rising edge where force_i is low and exactly one of sen_a_i and sen_b_i is high, count_o keeps its value and run_o becomes 0.
- R4: On a rising edge where force_i is low and both sen_a_i and sen_b_i are high, count_o increments on that same edge and run_o becomes 1.
- R5: Both sync enables low acts exactly like both high: the count increments on that edge and run_o is 1.
- R6: While stopped, count_o holds across any number of edges with mismatched enables, whichever of the two enables is the high one.
- R7: While force_i is high, run_o is 1 without waiting for an edge, and count_o increments on every edge whatever the sync enables are.
- R8: After force_i falls, run_o keeps the value 1 until the next rising edge. From that edge on, it follows the XNOR of the sync enables.
- R9: The count wraps from 2^WIDTH-1 (255 by default) to 0.
- R10: clr_i has priority over force_i and over clock edges. While clr_i is high, the count stays 0 across edges even when counting is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Counting clock, rising edge |
| clr_i | input | 1 | Asynchronous clear, active high |
| force_i | input | 1 | Asynchronous run-force, active high |
| sen_a_i | input | 1 | First synchronous enable |
| sen_b_i | input | 1 | Second synchronous enable |
| count_o | output | WIDTH | Current count |
| run_o | output | 1 | Run state register |

## Verification
The hardest situations to reach are the ones where the asynchronous inputs change between clock edges. In one, force_i rises while the sync enables disagree, and run_o must go high before any edge. In another, force_i falls with mismatched enables, and run_o must keep the value 1 until the following edge stops the count. The bench changes these inputs in the middle of the low clock phase. It samples the ports once before the next edge and again after it. It also fires clr_i mid-phase on a nonzero count, and clocks the counter all the way round to observe the wrap.

// File: rtl/gcnt_pkg.sv
package gcnt_pkg;

  localparam int unsigned GCNT_WIDTH_DEF = 8;

  // Counting is allowed when forced, or when the two sync enables agree.
  function automatic logic run_decision(input logic force_on,
                                        input logic sen_a,
                                        input logic sen_b);
    return force_on | ~(sen_a ^ sen_b);
  endfunction

endpackage

// File: rtl/gcnt_run_ctrl.sv
module gcnt_run_ctrl
  import gcnt_pkg::*;
(
  input  logic clk_i,
  input  logic clr_i,
  input  logic force_i,
  input  logic sen_a_i,
  input  logic sen_b_i,
  output logic advance_o,
  output logic run_q_o
);

  logic decision;

  always_comb begin
    decision = run_decision(force_i, sen_a_i, sen_b_i);
  end

  // The increment for this edge uses the same decision that is being registered.
  assign advance_o = decision;

  always_ff @(posedge clk_i or posedge clr_i or posedge force_i) begin
    if (clr_i) begin
      run_q_o <= 1'b1;
    end else if (force_i) begin
      run_q_o <= 1'b1;
    end else begin
      run_q_o <= decision;
    end
  end

endmodule

// File: rtl/gcnt_core.sv
module gcnt_core #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             clr_i,
  input  logic             advance_i,
  output logic [WIDTH-1:0] count_o
);

  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH:0]   carry;

  assign carry[0] = advance_i;

  // Synchronous toggle chain: each bit flips when all lower bits are one.
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign carry[i+1] = carry[i] & cnt_q[i];

    always_ff @(posedge clk_i or posedge clr_i) begin
      if (clr_i) begin
        cnt_q[i] <= 1'b0;
      end else if (carry[i]) begin
        cnt_q[i] <= ~cnt_q[i];
      end
    end
  end

  assign count_o = cnt_q;

endmodule

// File: rtl/gated_counter.sv
module gated_counter #(
  parameter int unsigned WIDTH = gcnt_pkg::GCNT_WIDTH_DEF
) (
  input  logic             clk_i,
  input  logic             clr_i,
  input  logic             force_i,
  input  logic             sen_a_i,
  input  logic             sen_b_i,
  output logic [WIDTH-1:0] count_o,
  output logic             run_o
);

  logic advance;

  gcnt_run_ctrl u_ctrl (
    .clk_i     (clk_i),
    .clr_i     (clr_i),
    .force_i   (force_i),
    .sen_a_i   (sen_a_i),
    .sen_b_i   (sen_b_i),
    .advance_o (advance),
    .run_q_o   (run_o)
  );

  gcnt_core #(.WIDTH(WIDTH)) u_core (
    .clk_i     (clk_i),
    .clr_i     (clr_i),
    .advance_i (advance),
    .count_o   (count_o)
  );

endmodule

// File: rtl/gated_counter_chk.sv
module gated_counter_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk_i,
  input logic             clr_i,
  input logic             force_i,
  input logic             sen_a_i,
  input logic             sen_b_i,
  input logic [WIDTH-1:0] count_o,
  input logic             run_o
);

  // R1
  clear_state_chk: assert property (@(posedge clk_i) disable iff (clr_i)
    $fell(clr_i) |-> (count_o == '0) && run_o);

  // R4
  agree_high_inc_chk: assert property (@(posedge clk_i) disable iff (clr_i)
    (!force_i && sen_a_i && sen_b_i) |=> (count_o == WIDTH'($past(count_o) + 1'b1)) && run_o);

  // R5
  agree_low_inc_chk: assert property (@(posedge clk_i) disable iff (clr_i)
    (!force_i && !sen_a_i && !sen_b_i) |=> (count_o == WIDTH'($past(count_o) + 1'b1)));

  // R3
  mismatch_hold_chk: assert property (@(posedge clk_i) disable iff (clr_i)
    (!force_i && (sen_a_i ^ sen_b_i)) |=> $stable(count_o) && (!run_o || force_i));

  // R7
  force_run_chk: assert property (@(posedge clk_i) disable iff (clr_i)
    force_i |-> run_o);

  // R7
  force_inc_chk: assert property (@(posedge clk_i) disable iff (clr_i)
    force_i |=> (count_o == WIDTH'($past(count_o) + 1'b1)));

endmodule

bind gated_counter gated_counter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i   (clk_i),
  .clr_i   (clr_i),
  .force_i (force_i),
  .sen_a_i (sen_a_i),
  .sen_b_i (sen_b_i),
  .count_o (count_o),
  .run_o   (run_o)
);

// File: tb/gated_counter_tb_top.sv
module gated_counter_tb_top;

  localparam int unsigned W = 8;

  logic         clk = 1'b0;
  logic         clr = 1'b0;
  logic         frc = 1'b0;
  logic         sa  = 1'b1;
  logic         sb  = 1'b1;
  logic [W-1:0] count;
  logic         run;

  int n_chk  = 0;
  int n_fail = 0;
  logic [W-1:0] exp_cnt = '0;

  always #4 clk = ~clk;

  gated_counter #(.WIDTH(W)) dut_i (
    .clk_i   (clk),
    .clr_i   (clr),
    .force_i (frc),
    .sen_a_i (sa),
    .sen_b_i (sb),
    .count_o (count),
    .run_o   (run)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Inputs are applied in the low phase; the model follows the requirements.
  task automatic tick(input logic a, input logic b, input logic f);
    sa = a; sb = b; frc = f;
    @(posedge clk);
    if (clr) exp_cnt = '0;
    else if (f | ~(a ^ b)) exp_cnt = exp_cnt + 1'b1;
    @(negedge clk);
  endtask

  task automatic do_clear();
    #1 clr = 1'b1;
    #1;
    check("R1 count on clear", int'(count), 0);
    check("R1 run on clear", int'(run), 1);
    exp_cnt = '0;
    @(negedge clk);
    clr = 1'b0;
  endtask

  task automatic t_reset_priority();
    clr = 1'b1;
    for (int i = 0; i < 3; i++) tick(1'b1, 1'b1, 1'b1);
    check("R10 count held at zero by clear", int'(count), 0);
    check("R10 run during clear", int'(run), 1);
    clr = 1'b0;
    exp_cnt = '0;
  endtask

  task automatic t_count();
    for (int i = 0; i < 4; i++) tick(1'b1, 1'b1, 1'b0);
    check("R4 count after both-high", int'(count), int'(exp_cnt));
    check("R4 run after both-high", int'(run), 1);
    for (int i = 0; i < 3; i++) tick(1'b0, 1'b0, 1'b0);
    check("R5 count after both-low", int'(count), 7);
    check("R2 model match", int'(count), int'(exp_cnt));
  endtask

  task automatic t_stop();
    logic [W-1:0] held;
    held = count;
    tick(1'b1, 1'b0, 1'b0);
    check("R3 count on stop edge", int'(count), int'(held));
    check("R3 run after stop", int'(run), 0);
    for (int i = 0; i < 3; i++) tick(1'b1, 1'b0, 1'b0);
    check("R6 hold with a high", int'(count), int'(held));
    for (int i = 0; i < 3; i++) tick(1'b0, 1'b1, 1'b0);
    check("R6 hold with b high", int'(count), int'(held));
    check("R6 run stays low", int'(run), 0);
  endtask

  task automatic t_sync_restart();
    logic [W-1:0] held;
    held = count;
    tick(1'b1, 1'b1, 1'b0);
    check("R4 restart edge increments", int'(count), int'(held) + 1);
    check("R4 run after restart", int'(run), 1);
  endtask

  task automatic t_force();
    logic [W-1:0] held;
    tick(1'b0, 1'b1, 1'b0);
    held = count;
    check("R3 stopped before force", int'(run), 0);
    #1 frc = 1'b1;
    #1;
    check("R7 run rises without edge", int'(run), 1);
    check("R7 count unchanged before edge", int'(count), int'(held));
    for (int i = 0; i < 3; i++) tick(1'b0, 1'b1, 1'b1);
    check("R7 forced counting", int'(count), int'(held) + 3);
    #1 frc = 1'b0;
    #1;
    check("R8 run held after force release", int'(run), 1);
    held = count;
    tick(1'b0, 1'b1, 1'b0);
    check("R8 edge after release stops", int'(run), 0);
    check("R8 count held after release", int'(count), int'(held));
    tick(1'b1, 1'b1, 1'b0);
    check("R8 run follows agree", int'(run), 1);
  endtask

  task automatic t_wrap();
    do_clear();
    for (int i = 0; i < 255; i++) tick(1'b0, 1'b0, 1'b0);
    check("R9 count at max", int'(count), 255);
    tick(1'b1, 1'b1, 1'b0);
    check("R9 wrap to zero", int'(count), 0);
    tick(1'b1, 1'b1, 1'b0);
    check("R9 counts on after wrap", int'(count), 1);
  endtask

  task automatic t_midrun_clear();
    for (int i = 0; i < 5; i++) tick(1'b1, 1'b1, 1'b0);
    check("R2 before clear", int'(count), int'(exp_cnt));
    do_clear();
    tick(1'b1, 1'b1, 1'b0);
    check("R1 counting after clear", int'(count), 1);
  endtask

  initial begin
    #1 clr = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R1 reset count", int'(count), 0);
    check("R1 reset run", int'(run), 1);
    clr = 1'b0;
    exp_cnt = '0;
    t_count();
    t_stop();
    t_sync_restart();
    t_force();
    t_reset_priority();
    t_wrap();
    t_midrun_clear();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 20000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog all-R actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule